// File: doc/BRIEF.md
# Stride-Programmable Lane Shuffle Crossbar

This block sits at the edge of a memory-compute array, on the data path. It rearranges a vector of equal-width lanes before the vector is written back or broadcast. A small configuration holds three settings: a pattern mode, a power-of-two stride and a lane selector. Every vector that passes through is permuted according to those settings. The lane mapping is therefore set up in advance, and neither software nor the array has to move elements one at a time.

Four patterns are available:

- **Pass-through** leaves every lane where it is.
- **Folding** shifts the vector down by the stride, so the upper part lines up with the lower part for a later combine.
- **Replication** repeats the first stride lanes across the whole vector.
- **Broadcast** copies one chosen lane to every output.

The result is registered. A new configuration never takes effect in the middle of a stream. A write that arrives while vectors are flowing is held until the first cycle with no valid input.

Top module: `lane_shuffle_xbar`

## Requirements
- R1: After reset, outValid is 0 and outData is all zeros. The active configuration is pass-through, so the first vector sent without any configuration write comes out unchanged.
- R2: The mode code 0 selects pass-through: output lane i equals input lane i. Lane i occupies bits [16*i+15 : 16*i].
- R3: The mode code 1 selects fold. Output lane i equals input lane i+stride when i+stride < 16. All remaining lanes are zero.
- R4: The mode code 2 selects replicate: output lane i equals input lane (i mod stride).
- R5: The mode code 3 selects broadcast: every output lane equals input lane cfgSel, where cfgSel is a 4-bit lane number.
- R6: The 2-bit stride code k gives a stride of 2^k. The codes 0, 1, 2 and 3 give strides 1, 2, 4 and 8.
- R7: outValid equals inValid one cycle later. The shuffled vector appears on outData in that same cycle.
- R8: When inValid is 0, outData keeps its previous value.
- R9: When cfgWrEn is high in a cycle with inValid low, the new settings apply to the vector presented in the next cycle.
- R10: A configuration write made while inValid is high is deferred. The vectors up to and including the first idle cycle use the old settings. If several writes occur during a busy stretch, the last one is applied at that idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgMode | input | 2 | Pattern code: 0 pass, 1 fold, 2 replicate, 3 broadcast |
| cfgStrideLog | input | 2 | Stride exponent; stride = 2^value |
| cfgSel | input | 4 | Source lane for broadcast |
| inValid | input | 1 | Input vector valid |
| inData | input | 256 | Input vector, 16 lanes of 16 bits |
| outValid | output | 1 | Output vector valid |
| outData | output | 256 | Shuffled output vector |

## Verification
The bench builds the block with its default parameters: 16 lanes of 16 bits and a 2-bit stride exponent. With these values every stride from 1 to 8 can be reached. They also make the fold boundary visible: between 1 and 8 upper lanes are zeroed, depending on the stride. Broadcast is checked from the first lane, the last lane and a middle lane. The stimulus mixes back-to-back vectors, idle gaps and configuration writes landing on busy cycles, so the deferral and last-write-wins rules are both exercised.

// File: rtl/lane_shuffle_pkg.sv
package lane_shuffle_pkg;

  typedef enum logic [1:0] {
    MODE_PASS  = 2'd0,
    MODE_FOLD  = 2'd1,
    MODE_REPL  = 2'd2,
    MODE_BCAST = 2'd3
  } shufMode_e;

  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic      loadOut;   // capture a shuffled vector this cycle
    logic      cfgApply;  // active settings change at this edge
    shufMode_e mode;      // active pattern mode
  } shufCtrl_t;

endpackage

// File: rtl/lane_shuffle_ctrl.sv
module lane_shuffle_ctrl
  import lane_shuffle_pkg::*;
#(
  parameter int STRIDE_LOG_W = 2,
  parameter int SEL_W        = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfgWrEn,
  input  logic [1:0]              cfgMode,
  input  logic [STRIDE_LOG_W-1:0] cfgStrideLog,
  input  logic [SEL_W-1:0]        cfgSel,
  input  logic                    inValid,
  output shufCtrl_t               ctrl,
  output logic [STRIDE_LOG_W-1:0] activeStrideLog,
  output logic [SEL_W-1:0]        activeSel
);

  shufMode_e                activeMode;
  logic                     pendFlag;
  shufMode_e                pendMode;
  logic [STRIDE_LOG_W-1:0]  pendStrideLog;
  logic [SEL_W-1:0]         pendSel;
  logic                     applyNow;

  // Settings change only at an edge that closes an idle cycle
  assign applyNow = !inValid && (cfgWrEn || pendFlag);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      activeMode      <= MODE_PASS;
      activeStrideLog <= '0;
      activeSel       <= '0;
    end else if (applyNow) begin
      if (cfgWrEn) begin
        activeMode      <= shufMode_e'(cfgMode);
        activeStrideLog <= cfgStrideLog;
        activeSel       <= cfgSel;
      end else begin
        activeMode      <= pendMode;
        activeStrideLog <= pendStrideLog;
        activeSel       <= pendSel;
      end
    end
  end

  // Shadow holding a write that arrived while a vector was in flight
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendFlag      <= 1'b0;
      pendMode      <= MODE_PASS;
      pendStrideLog <= '0;
      pendSel       <= '0;
    end else if (cfgWrEn && inValid) begin
      pendFlag      <= 1'b1;
      pendMode      <= shufMode_e'(cfgMode);
      pendStrideLog <= cfgStrideLog;
      pendSel       <= cfgSel;
    end else if (!inValid) begin
      pendFlag      <= 1'b0;
    end
  end

  always_comb begin
    ctrl.loadOut  = inValid;
    ctrl.cfgApply = applyNow;
    ctrl.mode     = activeMode;
  end

  // R10: settings never move under a valid vector
  assert_cfg_stable_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> ($stable(activeMode) && $stable(activeStrideLog) && $stable(activeSel)));

  // R10: a deferred write is consumed by the first idle cycle
  assert_pend_drained_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !pendFlag);

  // R9: an idle-cycle write is visible one cycle later
  assert_idle_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgWrEn && !inValid) |=> (activeMode == shufMode_e'($past(cfgMode))
                               && activeSel == $past(cfgSel)));

endmodule

// File: rtl/lane_shuffle_datapath.sv
module lane_shuffle_datapath
  import lane_shuffle_pkg::*;
#(
  parameter int LANES        = 16,
  parameter int LANE_W       = 16,
  parameter int STRIDE_LOG_W = 2,
  parameter int SEL_W        = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  shufCtrl_t                 ctrl,
  input  logic [STRIDE_LOG_W-1:0]   strideLog,
  input  logic [SEL_W-1:0]          sel,
  input  logic [LANES*LANE_W-1:0]   inData,
  output logic                      outValid,
  output logic [LANES*LANE_W-1:0]   outData
);

  localparam int VEC_W = LANES * LANE_W;

  logic [LANE_W-1:0] laneIn   [LANES];
  logic [SEL_W-1:0]  srcIdx   [LANES];
  logic              laneZero [LANES];
  logic [VEC_W-1:0]  shuffled;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign laneIn[i] = inData[i*LANE_W +: LANE_W];

    // Source lane index generation
    always_comb begin
      int strideI;
      int srcI;
      strideI     = 1 << strideLog;
      srcI        = i;
      laneZero[i] = 1'b0;
      unique case (ctrl.mode)
        MODE_PASS:  srcI = i;
        MODE_FOLD: begin
          if (i + strideI < LANES) srcI = i + strideI;
          else begin
            srcI        = 0;
            laneZero[i] = 1'b1;
          end
        end
        MODE_REPL:  srcI = i % strideI;
        MODE_BCAST: srcI = int'(sel);
        default:    srcI = i;
      endcase
      srcIdx[i] = SEL_W'(srcI);
    end

    // Lane multiplexer
    assign shuffled[i*LANE_W +: LANE_W] =
      laneZero[i] ? '0 : laneIn[srcIdx[i]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= ctrl.loadOut;
      if (ctrl.loadOut) outData <= shuffled;
    end
  end

  // R7: valid follows the input one cycle later
  assert_valid_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (outValid == $past(ctrl.loadOut)));

  // R8: data holds across idle cycles
  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.loadOut |=> $stable(outData));

  // R3: top lane is always emptied by a fold
  assert_fold_top_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.loadOut && ctrl.mode == MODE_FOLD) |=> (outData[VEC_W-1 -: LANE_W] == '0));

  // R5: broadcast makes first and last lane equal
  assert_bcast_uniform_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.loadOut && ctrl.mode == MODE_BCAST) |=>
      (outData[LANE_W-1:0] == outData[VEC_W-1 -: LANE_W]));

endmodule

// File: rtl/lane_shuffle_xbar.sv
module lane_shuffle_xbar
  import lane_shuffle_pkg::*;
#(
  parameter int LANES        = 16,
  parameter int LANE_W       = 16,
  parameter int STRIDE_LOG_W = 2,
  parameter int SEL_W        = $clog2(LANES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfgWrEn,
  input  logic [1:0]              cfgMode,
  input  logic [STRIDE_LOG_W-1:0] cfgStrideLog,
  input  logic [SEL_W-1:0]        cfgSel,
  input  logic                    inValid,
  input  logic [LANES*LANE_W-1:0] inData,
  output logic                    outValid,
  output logic [LANES*LANE_W-1:0] outData
);

  shufCtrl_t               ctrl;
  logic [STRIDE_LOG_W-1:0] activeStrideLog;
  logic [SEL_W-1:0]        activeSel;

  lane_shuffle_ctrl #(
    .STRIDE_LOG_W(STRIDE_LOG_W),
    .SEL_W       (SEL_W)
  ) ctrl_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfgWrEn        (cfgWrEn),
    .cfgMode        (cfgMode),
    .cfgStrideLog   (cfgStrideLog),
    .cfgSel         (cfgSel),
    .inValid        (inValid),
    .ctrl           (ctrl),
    .activeStrideLog(activeStrideLog),
    .activeSel      (activeSel)
  );

  lane_shuffle_datapath #(
    .LANES       (LANES),
    .LANE_W      (LANE_W),
    .STRIDE_LOG_W(STRIDE_LOG_W),
    .SEL_W       (SEL_W)
  ) dp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl     (ctrl),
    .strideLog(activeStrideLog),
    .sel      (activeSel),
    .inData   (inData),
    .outValid (outValid),
    .outData  (outData)
  );

endmodule

// File: tb/lane_shuffle_xbar_tb_top.sv
module lane_shuffle_xbar_tb_top;

  localparam int LANES = 16;
  localparam int LW    = 16;
  localparam int VW    = LANES * LW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfgWrEn;
  logic [1:0]    cfgMode;
  logic [1:0]    cfgStrideLog;
  logic [3:0]    cfgSel;
  logic          inValid;
  logic [VW-1:0] inData;
  logic          outValid;
  logic [VW-1:0] outData;

  always #4 clk = ~clk;  // 125 MHz

  lane_shuffle_xbar dut_i (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgMode(cfgMode),
    .cfgStrideLog(cfgStrideLog), .cfgSel(cfgSel), .inValid(inValid),
    .inData(inData), .outValid(outValid), .outData(outData)
  );

  int checks = 0;
  int fails  = 0;

  // Reference model state
  int            curMode = 0, curSl = 0, curSel = 0;
  bit            pendF = 0;
  int            pendMode, pendSl, pendSel;
  bit            expV = 0;
  logic [VW-1:0] expD = '0;
  bit            haveExp = 0;
  string         lastTag = "R1";

  task automatic check(input bit ok, input string tag, input logic [VW-1:0] act,
                       input logic [VW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [VW-1:0] refShuffle(input logic [VW-1:0] d, input int m,
                                               input int sl, input int s);
    logic [VW-1:0] r;
    int stride;
    r = '0;
    stride = 1 << sl;
    for (int i = 0; i < LANES; i++) begin
      int src;
      bit z;
      z = 0;
      case (m)
        0: src = i;
        1: begin src = i + stride; if (src >= LANES) z = 1; end
        2: src = i % stride;
        default: src = s;
      endcase
      if (!z) r[i*LW +: LW] = d[src*LW +: LW];
    end
    return r;
  endfunction

  task automatic step(input string tag, input bit v, input logic [VW-1:0] d,
                      input bit wr, input int m, input int sl, input int s);
    @(negedge clk);
    if (haveExp) begin
      check(outValid == expV, "R7", {255'b0, outValid}, {255'b0, expV});
      check(outData == expD, lastTag, outData, expD);
    end
    inValid = v; inData = d; cfgWrEn = wr;
    cfgMode = m[1:0]; cfgStrideLog = sl[1:0]; cfgSel = s[3:0];
    expV = v;
    if (v) expD = refShuffle(d, curMode, curSl, curSel);
    if (!v && (wr || pendF)) begin
      if (wr) begin curMode = m; curSl = sl; curSel = s; end
      else begin curMode = pendMode; curSl = pendSl; curSel = pendSel; end
      pendF = 0;
    end else if (wr && v) begin
      pendF = 1; pendMode = m; pendSl = sl; pendSel = s;
    end
    haveExp = 1;
    lastTag = tag;
  endtask

  function automatic logic [VW-1:0] rndVec();
    logic [VW-1:0] r;
    for (int i = 0; i < VW / 32; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  task automatic idle(input string tag);
    step(tag, 0, rndVec(), 0, 0, 0, 0);
  endtask

  task automatic cfg(input string tag, input int m, input int sl, input int s);
    step(tag, 0, rndVec(), 1, m, sl, s);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 0; cfgWrEn = 0; cfgMode = 0; cfgStrideLog = 0; cfgSel = 0;
    inValid = 0; inData = '0;
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R1", {255'b0, outValid}, '0);
    check(outData == '0, "R1", outData, '0);
    rst_n = 1;

    // R1: default config is pass-through
    step("R1", 1, rndVec(), 0, 0, 0, 0);
    // R2: pass-through stream
    for (int k = 0; k < 4; k++) step("R2", 1, rndVec(), 0, 0, 0, 0);
    // R3 / R6: fold at every stride code
    for (int sl = 0; sl < 4; sl++) begin
      cfg("R9", 1, sl, 0);
      for (int k = 0; k < 3; k++) step("R3", 1, rndVec(), 0, 0, 0, 0);
    end
    // R4 / R6: replicate at every stride code
    for (int sl = 0; sl < 4; sl++) begin
      cfg("R9", 2, sl, 0);
      for (int k = 0; k < 3; k++) step("R4", 1, rndVec(), 0, 0, 0, 0);
      idle("R8");
    end
    // R5: broadcast from first, middle and last lanes
    begin
      int sels[3] = '{0, 5, 15};
      foreach (sels[j]) begin
        cfg("R9", 3, 0, sels[j]);
        step("R5", 1, rndVec(), 0, 0, 0, 0);
        step("R5", 1, rndVec(), 0, 0, 0, 0);
      end
    end
    // R8: gaps between vectors hold the output
    step("R8", 1, rndVec(), 0, 0, 0, 0);
    idle("R8"); idle("R8"); idle("R8");
    // R10: writes during a busy stretch are deferred, last wins
    step("R10", 1, rndVec(), 1, 1, 2, 0);
    step("R10", 1, rndVec(), 0, 0, 0, 0);
    step("R10", 1, rndVec(), 1, 2, 1, 0);
    step("R10", 1, rndVec(), 0, 0, 0, 0);
    idle("R10");
    for (int k = 0; k < 3; k++) step("R10", 1, rndVec(), 0, 0, 0, 0);
    // R6: fold with the widest stride after a deferred write
    step("R6", 1, rndVec(), 1, 1, 3, 0);
    idle("R6");
    step("R6", 1, rndVec(), 0, 0, 0, 0);
    // R2: back to pass-through
    cfg("R9", 0, 0, 0);
    step("R2", 1, rndVec(), 0, 0, 0, 0);
    idle("R8");
    idle("R8");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule